// File: doc/BRIEF.md
# Parallel Port Host-Line Change Interrupt

This block sits beside the protocol engine of an IEEE 1284 peripheral port. It watches four host-driven control lines: the 1284 select line, the init line, host-busy and host-clock. It also takes single-cycle event pulses from the rest of the port. From these it keeps a small set of sticky status flags and drives one level-sensitive interrupt request towards the system.

Software chooses which transitions matter through two masks. One mask arms low-to-high edges and the other arms high-to-low edges, one bit per line. Any armed edge sets a shared signal-change flag. The init line is also read according to the port mode. In ECP mode, either edge of init is a direction reversal. In compatible mode, a falling init is a request to re-initialize the peripheral. Three more flags record an EPP address write, a negotiation change and an ID request. A per-flag enable mask and a global enable decide whether a flag raises the interrupt. A read-only identification register marks the parallel port as the requester while the interrupt is asserted. A manual-mode control bit is passed on only while the port is in compatible mode.

Top module: `ppsig_irq`

## Requirements
- R1: After reset, every register reads zero, and `irq_o` and `manual_o` are low.
- R2: Register 0 is the rising mask. It uses bit 3 for select, bit 2 for init, bit 1 for host-busy and bit 0 for host-clock, which is the same order as `host_lines_i`. A low-to-high change on a line whose bit is set in this mask sets status bit 4 (signal change).
- R3: Register 1 is the falling mask, with the same bit layout as the rising mask. A high-to-low change on a line whose bit is set in this mask sets status bit 4.
- R4: A line change whose direction is not armed in the matching mask leaves status bit 4 unchanged.
- R5: When `mode_i` is 2 (ECP), either edge on the init line sets status bit 2 (direction change). In any other mode, init edges leave bit 2 unchanged.
- R6: When `mode_i` is 0 (compatible), a falling init sets status bit 0 (re-init request). A rising init, or a falling init in any other mode, leaves bit 0 unchanged.
- R7: A pulse on `epp_addr_evt_i` sets status bit 3. A pulse on `neg_evt_i` sets bit 5. A pulse on `idreq_evt_i` sets bit 1.
- R8: Register 2 is the status register. Its flags are sticky, and writing 1 to a bit clears that bit. When a set event and a clear of the same bit land in the same cycle, the bit stays set.
- R9: `irq_o` is high exactly when bit 4 of register 4 (global enable) is set and at least one status bit has its matching bit set in register 3 (enable mask). It stays high until all enabled flags are cleared.
- R10: Bit 6 of register 6 reads as 1 while `irq_o` is high, and the other bits of that register read 0.
- R11: `manual_o` equals bit 7 of register 5 while `mode_i` is 0, and is 0 in every other mode.
- R12: A host line change presented before a rising clock edge shows in the status register after the fourth rising edge, and not after the third. The delay comes from two synchronizer stages, an edge register and the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_lines_i | input | 4 | Asynchronous host lines: [3] select, [2] init, [1] host-busy, [0] host-clock |
| mode_i | input | 2 | Port mode: 0 compatible, 1 EPP, 2 ECP, 3 other |
| epp_addr_evt_i | input | 1 | One-cycle pulse: EPP address cycle received |
| neg_evt_i | input | 1 | One-cycle pulse: negotiation change |
| idreq_evt_i | input | 1 | One-cycle pulse: ID request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Level interrupt request |
| manual_o | output | 1 | Manual-mode control, qualified by compatible mode |

## Verification
A wrong mask bit or a wrong mode decode shows as a wrong status bit in register 2 four cycles after the line moves. A lost or spurious flag therefore shows in the next status read. A broken clear path or broken set priority shows in the first read after the write, because the flag either survives or vanishes. Gating faults show on `irq_o` and in the identification bit in the same cycle the flags or enables change. This is why the bench compares the full status, the identification register and the interrupt after every step.

// File: rtl/ppsig_pkg.sv
package ppsig_pkg;
    localparam int NLINES    = 4;
    localparam int LN_SEL    = 3;
    localparam int LN_INIT   = 2;
    localparam int LN_BUSY   = 1;
    localparam int LN_HCLK   = 0;

    localparam int NSRC      = 6;
    localparam int ST_NEG    = 5;
    localparam int ST_SIG    = 4;
    localparam int ST_EPPA   = 3;
    localparam int ST_DIR    = 2;
    localparam int ST_IDREQ  = 1;
    localparam int ST_INIT   = 0;

    localparam int GEN_BIT   = 4;
    localparam int MAN_BIT   = 7;
    localparam int SRC_BIT   = 6;

    localparam logic [2:0] A_RISE = 3'd0;
    localparam logic [2:0] A_FALL = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_IEN  = 3'd3;
    localparam logic [2:0] A_GCTL = 3'd4;
    localparam logic [2:0] A_PCTL = 3'd5;
    localparam logic [2:0] A_SRC  = 3'd6;

    typedef enum logic [1:0] {
        PM_COMPAT = 2'd0,
        PM_EPP    = 2'd1,
        PM_ECP    = 2'd2,
        PM_OTHER  = 2'd3
    } port_mode_e;

    typedef struct packed {
        logic [NLINES-1:0] rmask;
        logic [NLINES-1:0] fmask;
        logic [NSRC-1:0]   stat;
        logic [NSRC-1:0]   ien;
        logic              gen;
        logic              manual;
    } ctl_regs_t;
endpackage

// File: rtl/ppsig_sync.sv
module ppsig_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/ppsig_edge.sv
module ppsig_edge #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
    } edge_st_t;

    edge_st_t e_d, e_q;

    always_comb begin
        e_d      = e_q;
        e_d.prev = level_i;
        e_d.rise = level_i & ~e_q.prev;
        e_d.fall = ~level_i & e_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    assign rise_o = e_q.rise;
    assign fall_o = e_q.fall;
endmodule

// File: rtl/ppsig_irq.sv
module ppsig_irq
    import ppsig_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int AW          = 3,
    parameter int DW          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] host_lines_i,
    input  logic [1:0]        mode_i,
    input  logic              epp_addr_evt_i,
    input  logic              neg_evt_i,
    input  logic              idreq_evt_i,
    input  logic              reg_wr_i,
    input  logic [AW-1:0]     reg_addr_i,
    input  logic [DW-1:0]     reg_wdata_i,
    output logic [DW-1:0]     reg_rdata_o,
    output logic              irq_o,
    output logic              manual_o
);
    logic [NLINES-1:0] lines_sync;
    logic [NLINES-1:0] rise_pls, fall_pls;

    ppsig_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (host_lines_i),
        .sync_o  (lines_sync)
    );

    ppsig_edge #(.W(NLINES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (lines_sync),
        .rise_o  (rise_pls),
        .fall_o  (fall_pls)
    );

    ctl_regs_t       r_d, r_q;
    logic [NSRC-1:0] set_vec, clr_vec;
    logic            is_ecp, is_compat, sig_hit, pending;

    always_comb begin
        r_d       = r_q;
        is_ecp    = (mode_i == PM_ECP);
        is_compat = (mode_i == PM_COMPAT);
        sig_hit   = |((rise_pls & r_q.rmask) | (fall_pls & r_q.fmask));

        set_vec           = '0;
        set_vec[ST_SIG]   = sig_hit;
        set_vec[ST_DIR]   = is_ecp & (rise_pls[LN_INIT] | fall_pls[LN_INIT]);
        set_vec[ST_INIT]  = is_compat & fall_pls[LN_INIT];
        set_vec[ST_EPPA]  = epp_addr_evt_i;
        set_vec[ST_NEG]   = neg_evt_i;
        set_vec[ST_IDREQ] = idreq_evt_i;

        clr_vec = '0;
        if (reg_wr_i) begin
            case (reg_addr_i)
                A_RISE:  r_d.rmask  = reg_wdata_i[NLINES-1:0];
                A_FALL:  r_d.fmask  = reg_wdata_i[NLINES-1:0];
                A_STAT:  clr_vec    = reg_wdata_i[NSRC-1:0];
                A_IEN:   r_d.ien    = reg_wdata_i[NSRC-1:0];
                A_GCTL:  r_d.gen    = reg_wdata_i[GEN_BIT];
                A_PCTL:  r_d.manual = reg_wdata_i[MAN_BIT];
                default: ;
            endcase
        end
        // set wins over a same-cycle clear
        r_d.stat = (r_q.stat & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pending  = |(r_q.stat & r_q.ien);
    assign irq_o    = r_q.gen & pending;
    assign manual_o = r_q.manual & (mode_i == PM_COMPAT);

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            A_RISE:  reg_rdata_o[NLINES-1:0] = r_q.rmask;
            A_FALL:  reg_rdata_o[NLINES-1:0] = r_q.fmask;
            A_STAT:  reg_rdata_o[NSRC-1:0]   = r_q.stat;
            A_IEN:   reg_rdata_o[NSRC-1:0]   = r_q.ien;
            A_GCTL:  reg_rdata_o[GEN_BIT]    = r_q.gen;
            A_PCTL:  reg_rdata_o[MAN_BIT]    = r_q.manual;
            A_SRC:   reg_rdata_o[SRC_BIT]    = irq_o;
            default: ;
        endcase
    end
endmodule

// File: rtl/ppsig_irq_chk.sv
module ppsig_irq_chk
    import ppsig_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] stat,
    input logic [NSRC-1:0] ien,
    input logic [1:0]      mode,
    input logic            irq,
    input logic            manual,
    input logic            wr,
    input logic [2:0]      addr
);
    // R8: a flag only drops after a status write
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stat) & ~stat)) |-> $past(wr && addr == A_STAT));

    // R5: direction flag rises only from an ECP-mode cycle
    p_dir_ecp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_DIR]) |-> $past(mode == PM_ECP));

    // R6: re-init flag rises only from a compatible-mode cycle
    p_init_compat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_INIT]) |-> $past(mode == PM_COMPAT));

    // R9: an interrupt always has an enabled pending flag behind it
    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|(stat & ien)));

    // R11: manual output only in compatible mode
    p_manual_r11: assert property (@(posedge clk) disable iff (!rst_n)
        manual |-> (mode == PM_COMPAT));
endmodule

bind ppsig_irq ppsig_irq_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat   (r_q.stat),
    .ien    (r_q.ien),
    .mode   (mode_i),
    .irq    (irq_o),
    .manual (manual_o),
    .wr     (reg_wr_i),
    .addr   (reg_addr_i)
);

// File: tb/ppsig_irq_tb.sv
module ppsig_irq_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] host_lines_i = '0;
    logic [1:0] mode_i = 2'd0;
    logic       epp_addr_evt_i = 1'b0, neg_evt_i = 1'b0, idreq_evt_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       irq_o, manual_o;

    int checks = 0, fails = 0;

    // bench model
    logic [3:0] m_rmask = '0, m_fmask = '0, m_lines = '0;
    logic [5:0] m_stat = '0, m_ien = '0;
    logic       m_gen = 0, m_man = 0;
    logic [1:0] m_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppsig_irq u_dut (.*);

    function automatic logic exp_irq();
        return m_gen && ((m_stat & m_ien) != 0);
    endfunction

    function automatic logic [5:0] line_sets(logic [3:0] o, logic [3:0] n, logic [1:0] md);
        logic [5:0] s;
        logic [3:0] r, f;
        r = n & ~o;
        f = o & ~n;
        s = '0;
        s[4] = |((r & m_rmask) | (f & m_fmask));
        s[2] = (md == 2'd2) && (r[2] || f[2]);
        s[0] = (md == 2'd0) && f[2];
        return s;
    endfunction

    task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr_i = 1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 0;
        case (a)
            3'd0: m_rmask = d[3:0];
            3'd1: m_fmask = d[3:0];
            3'd2: m_stat  = m_stat & ~d[5:0];
            3'd3: m_ien   = d[5:0];
            3'd4: m_gen   = d[4];
            3'd5: m_man   = d[7];
            default: ;
        endcase
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic set_lines(logic [3:0] n);
        logic [5:0] s;
        @(negedge clk);
        s = line_sets(m_lines, n, m_mode);
        host_lines_i = n;
        m_lines = n;
        repeat (6) @(negedge clk);
        m_stat = m_stat | s;
    endtask

    task automatic set_mode(logic [1:0] md);
        @(negedge clk);
        mode_i = md;
        m_mode = md;
        @(negedge clk);
    endtask

    task automatic pulse(logic e, logic n, logic i);
        @(negedge clk);
        epp_addr_evt_i = e; neg_evt_i = n; idreq_evt_i = i;
        @(negedge clk);
        epp_addr_evt_i = 0; neg_evt_i = 0; idreq_evt_i = 0;
        m_stat[3] |= e; m_stat[5] |= n; m_stat[1] |= i;
    endtask

    task automatic cmp_all(string tag);
        logic [7:0] d;
        rd(3'd2, d);
        check({tag, " status"}, d, {2'b0, m_stat});
        check({tag, " irq R9"}, {7'b0, irq_o}, {7'b0, exp_irq()});
        rd(3'd6, d);
        check({tag, " srcid R10"}, d, {1'b0, exp_irq(), 6'b0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h1284));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(a[2:0], d);
            check("R1 reg after reset", d, 8'h00);
        end
        check("R1 irq/manual", {6'b0, irq_o, manual_o}, 8'h00);

        // R12 latency: arm rising host-clock
        wr(3'd0, 8'h01);
        @(negedge clk);
        reg_addr_i = 3'd2;
        host_lines_i = 4'b0001;
        repeat (3) @(posedge clk);
        #1 check("R12 not set after 3 edges", reg_rdata_o, 8'h00);
        @(posedge clk);
        #1 check("R12 R2 set after 4 edges", reg_rdata_o, 8'h10);
        m_lines = 4'b0001; m_stat = 6'h10;
        wr(3'd2, 8'h10);
        cmp_all("R8 clear");

        // R4 unarmed falling edge on host-clock
        set_lines(4'b0000);
        cmp_all("R4 unarmed fall");
        check("R4 sig bit", {7'b0, m_stat[4]}, 8'h00);

        // R3 falling mask on host-busy
        wr(3'd1, 8'h02);
        set_lines(4'b0010);
        cmp_all("R4 rising busy unarmed");
        set_lines(4'b0000);
        cmp_all("R3 falling busy");
        rd(3'd2, d);
        check("R3 sig bit", d & 8'h10, 8'h10);
        wr(3'd2, 8'h3f);

        // R5 ECP init edges
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        set_mode(2'd2);
        set_lines(4'b0100);
        rd(3'd2, d);
        check("R5 ECP init rise", d, 8'h04);
        wr(3'd2, 8'h04);
        set_lines(4'b0000);
        rd(3'd2, d);
        check("R5 ECP init fall (no R6)", d, 8'h04);
        wr(3'd2, 8'h04);

        // R6 compatible init
        set_mode(2'd0);
        set_lines(4'b0100);
        rd(3'd2, d);
        check("R6 compat init rise", d, 8'h00);
        set_lines(4'b0000);
        rd(3'd2, d);
        check("R6 compat init fall", d, 8'h01);
        wr(3'd2, 8'h01);
        set_mode(2'd1);
        set_lines(4'b0100);
        set_lines(4'b0000);
        rd(3'd2, d);
        check("R5 R6 EPP init edges", d, 8'h00);

        // R7 event pulses
        pulse(1, 0, 0);
        rd(3'd2, d);
        check("R7 epp addr", d, 8'h08);
        pulse(0, 1, 1);
        rd(3'd2, d);
        check("R7 neg+idreq", d, 8'h2a);

        // R8 set wins over clear
        @(negedge clk);
        epp_addr_evt_i = 1; reg_wr_i = 1; reg_addr_i = 3'd2; reg_wdata_i = 8'h2a;
        @(negedge clk);
        epp_addr_evt_i = 0; reg_wr_i = 0;
        m_stat = 6'h08;
        rd(3'd2, d);
        check("R8 set beats clear", d, 8'h08);

        // R9 R10 gating
        wr(3'd3, 8'h08);
        cmp_all("R9 no global");
        wr(3'd4, 8'h10);
        cmp_all("R9 enabled");
        check("R9 irq high", {7'b0, irq_o}, 8'h01);
        wr(3'd3, 8'h04);
        cmp_all("R9 mask off");
        wr(3'd3, 8'h08);
        wr(3'd2, 8'h08);
        cmp_all("R9 cleared");

        // R11 manual
        wr(3'd5, 8'h80);
        @(negedge clk);
        check("R11 EPP manual", {7'b0, manual_o}, 8'h00);
        set_mode(2'd0);
        check("R11 compat manual", {7'b0, manual_o}, 8'h01);
        wr(3'd5, 8'h00);
        check("R11 cleared", {7'b0, manual_o}, 8'h00);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int unsigned act = $urandom_range(0, 5);
            case (act)
                0: set_mode(2'($urandom_range(0, 3)));
                1: set_lines(4'($urandom));
                2: wr(3'($urandom_range(0, 1)), 8'($urandom));
                3: wr(3'($urandom_range(2, 4)), 8'($urandom));
                4: pulse(1'($urandom), 1'($urandom), 1'($urandom));
                default: set_lines(4'($urandom));
            endcase
            cmp_all("R2 R3 R5 R6 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule